// File: doc/BRIEF.md
# Software Write-Protection Command Decoder

This block sits between the bus interface of a parallel byte-wide nonvolatile memory and its page buffer. Every qualified byte write passes through it. For each write it decides whether the byte may be loaded into the page buffer or must be dropped. It does this by matching short address/data command sequences. An arming sequence of three writes turns protection on and opens one page-load window. A six-write sequence turns protection off. Bytes that belong to a command are never loaded.

The protection flag stands in for a nonvolatile bit. It is an ordinary register with a parameterised reset value. The page controller pulses `prog_done` when its internal program cycle ends. While the window is open, that pulse closes the window and the block returns to the locked state. How long the window lasts is set outside this block.

The decoder is a seven-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No partial match is held. |
| `ST_K1` | The first key write (AA at 5555) has been seen. |
| `ST_K2` | The second key write (55 at 2AAA) has been seen. |
| `ST_D3` | The disable branch has been taken (80 at 5555). |
| `ST_D4` | The disable branch has seen its repeated first key (AA at 5555). |
| `ST_D5` | The disable branch has seen its repeated second key (55 at 2AAA). |
| `ST_OPEN` | The page-load window is open. |

Transitions, all taken on a write strobe except where noted:

| From | Condition | To |
|---|---|---|
| `ST_IDLE` | key1 | `ST_K1` |
| `ST_K1` | key2 | `ST_K2` |
| `ST_K2` | A0 at 5555 | `ST_OPEN`, and the protection flag is set |
| `ST_K2` | 80 at 5555 | `ST_D3` |
| `ST_D3` | key1 | `ST_D4` |
| `ST_D4` | key2 | `ST_D5` |
| `ST_D5` | 20 at 5555 | `ST_IDLE`, and the protection flag is cleared |
| Any matching state | A mismatching write | Restart: `ST_K1` if that write is key1, otherwise `ST_IDLE` |
| `ST_OPEN` | `prog_done`, with or without a write | `ST_IDLE` |

Top module: `wp_cmd_decoder`

## Requirements
- R1: After reset, `prot_on` equals the reset default (0). While no write is strobed, `wr_allow` is 0.
- R2: While `prot_on` is 0 and no partial match is pending, a write that is not key1 (data AA at address 5555) has `wr_allow` high in the same cycle.
- R3: The writes AA at 5555, then 55 at 2AAA, then A0 at 5555 arm the window. `prot_on` is 1 from the cycle after the third write. None of the three writes is allowed.
- R4: While the window is open, every write is allowed. A `prog_done` pulse closes the window. `prot_on` stays 1 after that.
- R5: While `prot_on` is 1 and the window is closed, every write is blocked.
- R6: The six writes AA at 5555, 55 at 2AAA, 80 at 5555, AA at 5555, 55 at 2AAA, 20 at 5555 clear `prot_on` from the cycle after the sixth write. None of the six is allowed. `prot_on` changes only in the cycle after a write.
- R7: Command address matching compares address bits 14:0 only, so bit 15 has no effect.
- R8: A write that breaks a partial match discards that match. The breaking write is then judged as a first step: key1 starts a new match and is blocked, and any other write follows R2 or R5.
- R9: Key1 is consumed and never allowed outside the window, whatever the value of `prot_on`.
- R10: A `prog_done` pulse outside the window has no effect. A write in the same cycle as the closing `prog_done` is still allowed.
- R11: At the third step, data 80 at 5555 takes the disable branch and data A0 at 5555 arms the window. Any other third write restarts the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One qualified byte write in this cycle |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| prog_done | input | 1 | Pulse: the internal program cycle has ended |
| wr_allow | output | 1 | This cycle's write may enter the page buffer |
| prot_on | output | 1 | Protection flag |

## Verification
Two events can land in the same cycle: a page-load write and the `prog_done` pulse that closes the window. A third case is a mismatching write that both ends one partial match and starts another. The bench provokes the first by raising `prog_done` alongside window writes, and by random pulses while a reference model runs. That model requires the write to be allowed and the next write to be judged as locked. For the second case, the bench stops the disable sequence at each of its six steps, injects every command and ordinary token there, and compares each write's allow and the following protection state.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5, ST_OPEN
    } wpd_state_t;

    typedef enum logic [2:0] {
        TK_OTHER, TK_KEY1, TK_KEY2, TK_ARM, TK_SPLIT, TK_OFF
    } wpd_tok_t;

    localparam logic [15:0] CMD_ADDR_A = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY1_DATA  = 8'hAA;
    localparam logic [7:0]  KEY2_DATA  = 8'h55;
    localparam logic [7:0]  ARM_DATA   = 8'hA0;
    localparam logic [7:0]  SPLIT_DATA = 8'h80;
    localparam logic [7:0]  OFF_DATA   = 8'h20;
endpackage

// File: rtl/wpd_match.sv
module wpd_match
    import wpd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wpd_tok_t          tok
);
    localparam int CMP_W = ADDR_W - 1;

    logic at_a, at_b;

    always_comb begin
        at_a = (addr[CMP_W-1:0] == CMD_ADDR_A[CMP_W-1:0]);
        at_b = (addr[CMP_W-1:0] == CMD_ADDR_B[CMP_W-1:0]);
        tok  = TK_OTHER;
        if (at_a && data == DATA_W'(KEY1_DATA))       tok = TK_KEY1;
        else if (at_b && data == DATA_W'(KEY2_DATA))  tok = TK_KEY2;
        else if (at_a && data == DATA_W'(ARM_DATA))   tok = TK_ARM;
        else if (at_a && data == DATA_W'(SPLIT_DATA)) tok = TK_SPLIT;
        else if (at_a && data == DATA_W'(OFF_DATA))   tok = TK_OFF;
    end
endmodule

// File: rtl/wpd_flag.sv
module wpd_flag #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= INIT;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/wp_cmd_decoder.sv
module wp_cmd_decoder
    import wpd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter bit PROT_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              wr_allow,
    output logic              prot_on
);
    wpd_state_t state_q, state_d;
    wpd_tok_t   tok;
    logic       set_p, clr_p;
    logic       allow_c;
    wpd_state_t restart_st;
    logic       restart_ok;

    wpd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr(wr_addr), .data(wr_data), .tok(tok)
    );

    wpd_flag #(.INIT(PROT_INIT)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(set_p), .clr_i(clr_p), .q(prot_on)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        restart_st = (tok == TK_KEY1) ? ST_K1 : ST_IDLE;
        restart_ok = (tok != TK_KEY1) && !prot_on;
        state_d    = state_q;
        allow_c    = 1'b0;
        set_p      = 1'b0;
        clr_p      = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                allow_c = 1'b1;
                if (prog_done) state_d = ST_IDLE;
            end
            ST_IDLE: if (wr_stb) begin
                state_d = restart_st;
                allow_c = restart_ok;
            end
            ST_K1: if (wr_stb) begin
                if (tok == TK_KEY2) state_d = ST_K2;
                else begin state_d = restart_st; allow_c = restart_ok; end
            end
            ST_K2: if (wr_stb) begin
                if (tok == TK_ARM) begin
                    state_d = ST_OPEN;
                    set_p   = 1'b1;
                end else if (tok == TK_SPLIT) state_d = ST_D3;
                else begin state_d = restart_st; allow_c = restart_ok; end
            end
            ST_D3: if (wr_stb) begin
                if (tok == TK_KEY1) state_d = ST_D4;
                else begin state_d = restart_st; allow_c = restart_ok; end
            end
            ST_D4: if (wr_stb) begin
                if (tok == TK_KEY2) state_d = ST_D5;
                else begin state_d = restart_st; allow_c = restart_ok; end
            end
            ST_D5: if (wr_stb) begin
                if (tok == TK_OFF) begin
                    state_d = ST_IDLE;
                    clr_p   = 1'b1;
                end else begin state_d = restart_st; allow_c = restart_ok; end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_allow = wr_stb && allow_c;
    end
endmodule

// File: rtl/wpd_chk.sv
module wpd_chk
    import wpd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prog_done,
    input logic              wr_allow,
    input logic              prot_on,
    input wpd_state_t        state_q
);
    localparam int CMP_W = ADDR_W - 1;

    // R6
    prot_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(prot_on));

    // R3
    prot_rise_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> ($past(wr_data) == DATA_W'(ARM_DATA)) &&
                           ($past(wr_addr[CMP_W-1:0]) == CMD_ADDR_A[CMP_W-1:0]));

    // R6
    prot_fall_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> ($past(wr_data) == DATA_W'(OFF_DATA)));

    // R5
    locked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && prot_on) |-> (state_q == ST_OPEN));

    // R9
    key1_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && state_q != ST_OPEN && wr_data == DATA_W'(KEY1_DATA) &&
         wr_addr[CMP_W-1:0] == CMD_ADDR_A[CMP_W-1:0]) |-> !wr_allow);

    // R4
    window_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && prog_done) |=> (state_q == ST_IDLE));
endmodule

bind wp_cmd_decoder wpd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wpd_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow),
    .prot_on(prot_on), .state_q(state_q)
);

// File: tb/test_wp_cmd_decoder.sv
`timescale 1ns/1ps
module test_wp_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic        wr_allow, prot_on;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    // reference model state
    int m_stg = 0;
    bit m_open = 0;
    bit m_prot = 0;

    always #4 clk = ~clk;

    wp_cmd_decoder i_wp_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow),
        .prot_on(prot_on)
    );

    function automatic logic [15:0] t_addr(int i);
        case (i)
            0, 2, 3, 4: return 16'h5555;
            1:          return 16'h2AAA;
            5:          return 16'h1234;
            6:          return 16'hD555;
            default:    return 16'hAAAA;
        endcase
    endfunction

    function automatic logic [7:0] t_data(int i);
        case (i)
            0, 6:    return 8'hAA;
            1, 7:    return 8'h55;
            2:       return 8'hA0;
            3:       return 8'h80;
            4:       return 8'h20;
            default: return 8'h5A;
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic model(bit stb, logic [15:0] a, logic [7:0] d, bit done, output bit allow);
        bit k1, k2, arm, spl, off;
        k1  = (a[14:0] == 15'h5555) && d == 8'hAA;
        k2  = (a[14:0] == 15'h2AAA) && d == 8'h55;
        arm = (a[14:0] == 15'h5555) && d == 8'hA0;
        spl = (a[14:0] == 15'h5555) && d == 8'h80;
        off = (a[14:0] == 15'h5555) && d == 8'h20;
        allow = 0;
        if (m_open) begin
            allow = stb;
            if (done) m_open = 0;
            return;
        end
        if (!stb) return;
        if ((m_stg == 0 || m_stg == 3) && k1) m_stg++;
        else if ((m_stg == 1 || m_stg == 4) && k2) m_stg++;
        else if (m_stg == 2 && arm) begin m_open = 1; m_prot = 1; m_stg = 0; end
        else if (m_stg == 2 && spl) m_stg = 3;
        else if (m_stg == 5 && off) begin m_prot = 0; m_stg = 0; end
        else if (k1) m_stg = 1;
        else begin m_stg = 0; allow = !m_prot; end
    endtask

    task automatic op(string tag, bit stb, logic [15:0] a, logic [7:0] d, bit done);
        bit exp;
        @(negedge clk);
        check(tag, prot_on, m_prot, "prot_on");
        wr_stb = stb; wr_addr = a; wr_data = d; prog_done = done;
        #1;
        model(stb, a, d, done, exp);
        check(tag, wr_allow, exp, "wr_allow");
        @(posedge clk);
        #1;
        wr_stb = 0; prog_done = 0;
    endtask

    task automatic wt(string tag, int i, bit done = 0);
        op(tag, 1, t_addr(i), t_data(i), done);
    endtask

    task automatic do_disable(string tag);
        wt(tag, 0); wt(tag, 1); wt(tag, 3); wt(tag, 0); wt(tag, 1); wt(tag, 4);
    endtask

    task automatic do_arm(string tag);
        wt(tag, 0); wt(tag, 1); wt(tag, 2);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", prot_on, 1'b0, "prot_on reset");
        check("R1", wr_allow, 1'b0, "wr_allow idle");
        rst_n = 1;

        // R2 ordinary writes pass while unprotected
        wt("R2", 5); wt("R2", 7);
        // R9 key1 consumed even while unprotected
        wt("R9", 0); wt("R9", 5);
        // R3 arm, R4 window writes, close together with a write (R10)
        do_arm("R3");
        wt("R4", 5); wt("R4", 1);
        wt("R10", 5, 1);
        wt("R5", 5);
        op("R10", 0, 16'h0, 8'h0, 1);
        wt("R5", 7);
        // R7 bit 15 ignored: arm using D555
        wt("R7", 6); wt("R7", 1); op("R7", 1, 16'hD555, 8'hA0, 0);
        wt("R7", 5, 1);
        // R11 split toward disable, then R6 completes it
        wt("R11", 0); wt("R11", 1); wt("R11", 3);
        wt("R6", 0); wt("R6", 1); wt("R6", 4);
        wt("R6", 5);
        // R11 other third write restarts
        wt("R11", 0); wt("R11", 1); wt("R11", 5);

        // R8 sweep: break the disable sequence at every step with every token
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 6; k++) begin
                for (int b = 0; b < 8; b++) begin
                    wt("R8", 5);
                    if (m_open) op("R8", 0, 16'h0, 8'h0, 1);
                    if (p == 1 && !m_prot) begin do_arm("R8"); op("R8", 0, 16'h0, 8'h0, 1); end
                    if (p == 0 && m_prot) do_disable("R8");
                    for (int s = 0; s < k; s++) begin
                        int seqi[6] = '{0, 1, 3, 0, 1, 4};
                        wt("R8", seqi[s]);
                    end
                    wt("R8", b);
                    wt("R8", 5);
                    if (m_open) op("R8", 0, 16'h0, 8'h0, 1);
                end
            end
        end

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 10);
            bit dn = ($urandom % 8) == 0;
            if (r < 8) wt("R2", r, dn);
            else op("R10", 0, 16'h0, 8'h0, dn);
        end

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule